// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block runs on the host system clock and reads a 10-bit successive-approximation converter over a three-wire serial link. It drives one active-low select line, which serves as the converter's chip-select and output-enable at once, and a serial clock. The serial clock comes from the system clock through a divider whose half-period is derived from two frequency parameters. A parameter fixes the serial clock polarity at build time: idle-low with rising-edge sampling, or idle-high with rising-edge sampling. The data line is sampled on rising serial-clock edges. The four leading zero bits are dropped, and the ten data bits are assembled MSB first.

A one-cycle start request launches a single frame. A frame is either the minimum 14-clock transfer or a 16-clock transfer that a byte-oriented host would issue as two 8-bit reads; the choice is taken when the frame starts. When the frame finishes, the 10-bit result is published with a single-cycle valid strobe. A 16-bit view of it is also given, sign-extended when the bipolar input is high and zero-extended otherwise. In continuous mode the controller chains frames without gaps. The select line goes high for one half-period and falls again on the frame's final falling clock edge.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, csN is high, sclk sits at its idle level (0 when CPOL=0, 1 when CPOL=1), and resultValid is low.
- R2: A startReq sampled high while idle pulls csN low at that same clock edge, and the first sclk transition follows exactly HALF system cycles later, where HALF = SYS_HZ/(2*SCLK_HZ) (5 cycles, 100 ns, at the defaults).
- R3: Once csN falls, sclk toggles every HALF system cycles. Whenever no frame is active, sclk rests at its idle level.
- R4: sdi is sampled on rising sclk edges. Rising edges 1 to 4 carry zeros and are discarded. Rising edges 5 to 14 carry data bits 9 down to 0, MSB first.
- R5: With longFrame low a frame has 14 rising edges; with it high, 16. The setting is latched when the frame starts, and csN rises on the same edge as the frame's last rising sclk edge.
- R6: resultValid is high for exactly one system cycle, the cycle after the 14th rising edge has been sampled, and result holds its value until the next publication.
- R7: resultExt equals result with bit 9 copied into bits 15:10 when bipolar is high, and with bits 15:10 zero when bipolar is low.
- R8: startReq has no effect while a frame is active or while csN is in its post-frame high time; no extra frame and no extra resultValid result from it.
- R9: With contMode high at the end of a frame, csN stays high for exactly one half-period and then falls again. With CPOL=0 that fall lands on the same edge as the frame's last falling sclk edge. With contMode low, the controller returns to idle.
- R10: Between frames, csN stays high for at least HALF system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one frame (honoured only when idle) |
| contMode | input | 1 | Chain frames back to back |
| longFrame | input | 1 | 1: 16-clock frame, 0: 14-clock frame |
| bipolar | input | 1 | Sign-extend the 16-bit view |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low select, also used as output enable |
| sclk | output | 1 | Serial clock |
| result | output | 10 | Latest conversion code |
| resultValid | output | 1 | One-cycle strobe on a new result |
| resultExt | output | 16 | Result extended to 16 bits |

## Verification
The bench runs an idle-low and an idle-high instance side by side. Each is paired with a behavioural converter that advances its bit pointer only on falling edges that follow a rising edge. An off-by-one in where the MSB is taken therefore shows up as a shifted code. The bench goes after:
- the all-ones, all-zeros, 0x200 and 0x1FF codes, which catch bit-order and extension faults;
- start pulses issued mid-frame, which catch a controller that restarts or emits a second strobe;
- frames of both lengths, which catch a miscounted edge total when csN rises;
- continuous chaining, where a wrong gap length moves every later valid strobe off its predicted cycle, and where a mode-0 fall that misses the last falling clock edge is reported at once.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  // Strobes from the sequencing logic to the bit datapath.
  typedef struct packed {
    logic shiftEn;   // take sdi into the assembly register
    logic publish;   // this shift completes the code
  } rdStrobe_t;

endpackage

// File: rtl/sar_rd_tick.sv
module sar_rd_tick #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] divCnt;

  assign tick = run && (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            divCnt <= '0;
    else if (!run || tick) divCnt <= '0;
    else                  divCnt <= divCnt + 1'b1;
  end

  // R3: the divider never passes its terminal count
  assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= LAST);

endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int CPOL       = 0,
  parameter int LEAD_ZEROS = 4,
  parameter int RES_BITS   = 10,
  parameter int LONG_CLKS  = 16,
  parameter int CNT_W      = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      contMode,
  input  logic      longFrame,
  input  logic      tick,
  output logic      csN,
  output logic      sclk,
  output logic      divRun,
  output rdStrobe_t stb
);
  localparam logic IDLE_LVL = (CPOL != 0);
  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(LEAD_ZEROS + RES_BITS);
  localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_CLKS);
  localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(LEAD_ZEROS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(LEAD_ZEROS + RES_BITS);

  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_GAP} rdState_e;

  rdState_e         state;
  logic             phase;
  logic             longLat;
  logic [CNT_W-1:0] riseCnt;
  logic [CNT_W-1:0] kNext;
  logic [CNT_W-1:0] frameLen;
  logic             riseNow;
  logic             lastRise;

  assign sclk     = phase ^ IDLE_LVL;
  assign divRun   = (state != ST_IDLE);
  assign frameLen = longLat ? LONG_LEN : SHORT_LEN;
  assign kNext    = riseCnt + 1'b1;
  assign riseNow  = (state == ST_ACTIVE) && tick && !sclk;
  assign lastRise = riseNow && (kNext == frameLen);

  always_comb begin
    stb         = '0;
    stb.shiftEn = riseNow && (kNext >= FIRST_BIT) && (kNext <= LAST_BIT);
    stb.publish = riseNow && (kNext == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      csN     <= 1'b1;
      phase   <= 1'b0;
      longLat <= 1'b0;
      riseCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_ACTIVE;
            csN     <= 1'b0;
            phase   <= 1'b0;
            riseCnt <= '0;
            longLat <= longFrame;
          end
        end
        ST_ACTIVE: begin
          if (tick) begin
            phase <= ~phase;
            if (riseNow) riseCnt <= kNext;
            if (lastRise) begin
              csN   <= 1'b1;
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            phase <= 1'b0;
            if (contMode) begin
              state   <= ST_ACTIVE;
              csN     <= 1'b0;
              riseCnt <= '0;
              longLat <= longFrame;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_start_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (!csN && state == ST_ACTIVE));

  assert_sclk_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(sclk));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (sclk == IDLE_LVL && csN));

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= frameLen);

  assert_cs_rise_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (riseCnt == frameLen));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !tick) |=> (state == ST_ACTIVE && !csN));

endmodule

// File: rtl/sar_rd_data.sv
module sar_rd_data
  import sar_rd_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int OUT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdi,
  input  rdStrobe_t           stb,
  input  logic                bipolar,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic [OUT_W-1:0]    resultExt
);
  localparam int EXT_W = OUT_W - RES_BITS;
  localparam int BC_W  = $clog2(RES_BITS + 1);

  logic [RES_BITS-1:0] shiftReg;
  logic [RES_BITS-1:0] nextCode;

  assign nextCode = {shiftReg[RES_BITS-2:0], sdi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= stb.publish;
      if (stb.shiftEn) shiftReg <= nextCode;
      if (stb.publish) result   <= nextCode;
    end
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign resultExt = {{EXT_W{bipolar & result[RES_BITS-1]}}, result};
    end else begin : g_noext
      logic unusedBip;
      assign unusedBip = bipolar;
      assign resultExt = result[OUT_W-1:0];
    end
  endgenerate

  // checker state: bits taken since the last publication
  logic [BC_W-1:0] bitsSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             bitsSeen <= '0;
    else if (stb.shiftEn && stb.publish)   bitsSeen <= '0;
    else if (stb.shiftEn)                  bitsSeen <= bitsSeen + 1'b1;
  end

  assert_ten_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.publish |-> (stb.shiftEn && bitsSeen == BC_W'(RES_BITS - 1)));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.publish) |-> $stable(result));

endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int SYS_HZ     = 50_000_000,
  parameter int SCLK_HZ    = 5_000_000,
  parameter int CPOL       = 0,
  parameter int LEAD_ZEROS = 4,
  parameter int RES_BITS   = 10,
  parameter int LONG_CLKS  = 16,
  parameter int OUT_W      = 16,
  parameter int CNT_W      = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                contMode,
  input  logic                longFrame,
  input  logic                bipolar,
  input  logic                sdi,
  output logic                csN,
  output logic                sclk,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic [OUT_W-1:0]    resultExt
);
  localparam int HALF = SYS_HZ / (2 * SCLK_HZ);

  logic      tick;
  logic      divRun;
  rdStrobe_t stb;

  sar_rd_tick #(.HALF(HALF)) uTick (
    .clk(clk), .rstN(rstN), .run(divRun), .tick(tick)
  );

  sar_rd_ctrl #(
    .CPOL(CPOL), .LEAD_ZEROS(LEAD_ZEROS), .RES_BITS(RES_BITS),
    .LONG_CLKS(LONG_CLKS), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .longFrame(longFrame), .tick(tick), .csN(csN), .sclk(sclk),
    .divRun(divRun), .stb(stb)
  );

  sar_rd_data #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) uData (
    .clk(clk), .rstN(rstN), .sdi(sdi), .stb(stb), .bipolar(bipolar),
    .result(result), .resultValid(resultValid), .resultExt(resultExt)
  );

  // R6: a strobe is only ever raised while a frame is running or just closed
  assert_valid_in_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> divRun);

endmodule

// File: tb/tb_serial_adc_reader.sv
module rd_monitor #(
  parameter int CPOL = 0,
  parameter int HALF = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        contMode,
  input  logic        longFrame,
  input  logic        bipolar,
  input  logic        csN,
  input  logic        sclk,
  input  logic [9:0]  result,
  input  logic        resultValid,
  input  logic [15:0] resultExt,
  output logic        sdi,
  output int          nChecks,
  output int          nFails
);
  // behavioural model state (edge indices)
  int  cyc, t0, lsbEdge, endEdge, nLen;
  bit  active, wasIdle, expValid, contRestart;
  // converter model state
  bit  prevCs, prevSclk, seenRise;
  int  fcnt, frameNo, riseSeen, expN, highCnt, lowCnt;
  bit  waitFirst;
  logic [9:0] curCode;
  logic [9:0] expq[$];

  function automatic logic [9:0] codeFor(int i);
    case (i % 6)
      0: codeFor = 10'h3FF;
      1: codeFor = 10'h000;
      2: codeFor = 10'h200;
      3: codeFor = 10'h1FF;
      default: codeFor = 10'((i * 173 + 'h2A5) & 'h3FF);
    endcase
  endfunction

  function automatic logic bitAt(int i, logic [9:0] c);
    if (i < 4 || i > 13) bitAt = 1'b0;
    else bitAt = c[13 - i];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s cpol=%0d t=%0t actual=%0h expected=%0h", tag, CPOL, $time, act, exp);
    end
  endtask

  task automatic setupFrame();
    nLen    = longFrame ? 16 : 14;
    lsbEdge = t0 + HALF * (27 + CPOL);
    endEdge = t0 + HALF * (2 * nLen + CPOL);
  endtask

  initial begin
    nChecks = 0; nFails = 0; sdi = 1'b0;
    active = 0; cyc = 0; expValid = 0; contRestart = 0;
    prevCs = 1; prevSclk = (CPOL != 0); seenRise = 0; fcnt = 0; frameNo = 0;
    riseSeen = 0; expN = 14; highCnt = 100; lowCnt = 0; waitFirst = 0; curCode = '0;
    t0 = 0; lsbEdge = -1; endEdge = -1; nLen = 14;
  end

  // cycle-level model of when things must happen
  always @(posedge clk) begin
    if (!rstN) begin
      active = 0; cyc = 0; expValid = 0;
    end else begin
      cyc++;
      wasIdle  = !active;
      expValid = active && (cyc == lsbEdge);
      if (active && cyc == endEdge) begin
        if (contMode) begin t0 = cyc; setupFrame(); contRestart = 1; end
        else active = 0;
      end
      if (wasIdle && startReq) begin
        active = 1; t0 = cyc; setupFrame();
      end
    end
  end

  // converter model and port checks, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      // R6 strobe timing compared on every cycle against the model
      chk(resultValid == expValid, "R6/R8 valid timing", resultValid, expValid);
      if (!active) chk(sclk == (CPOL != 0), "R3 idle level", sclk, CPOL);
      if (resultValid) begin
        logic [9:0] e;
        e = (expq.size() > 0) ? expq.pop_front() : 10'h3AA;
        chk(result == e, "R4 result code", result, e);
        chk(resultExt == (bipolar ? {{6{e[9]}}, e} : {6'b0, e}), "R7 extension",
            resultExt, bipolar ? {{6{e[9]}}, e} : {6'b0, e});
      end
      if (prevCs && !csN) begin
        chk(highCnt >= HALF, "R10 cs high width", highCnt, HALF);
        if (contRestart) begin
          if (CPOL == 0) chk(prevSclk && !sclk, "R9 fall on last falling edge", sclk, 0);
          else           chk(sclk == 1'b1, "R9 restart at idle level", sclk, 1);
          contRestart = 0;
        end
        curCode = codeFor(frameNo); frameNo++;
        expq.push_back(curCode);
        fcnt = 0; seenRise = 0; sdi = 1'b0; riseSeen = 0; expN = nLen;
        lowCnt = 1; waitFirst = 1; highCnt = 0;
      end else if (!csN) begin
        if (waitFirst) begin
          if (sclk != prevSclk) begin
            chk(lowCnt == HALF, "R2 setup before first edge", lowCnt, HALF);
            waitFirst = 0;
          end else lowCnt++;
        end
        if (!prevSclk && sclk) begin seenRise = 1; riseSeen++; end
        if (prevSclk && !sclk && seenRise) begin fcnt++; sdi = bitAt(fcnt, curCode); end
      end else begin
        if (!prevCs && !prevSclk && sclk) riseSeen++;
        if (!prevCs) chk(riseSeen == expN, "R5 rising edges per frame", riseSeen, expN);
        highCnt++;
        sdi = 1'b0;
      end
      prevCs = csN; prevSclk = sclk;
    end
  end
endmodule

module tb_serial_adc_reader;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, contMode = 1'b0, longFrame = 1'b0, bipolar = 1'b0;
  logic sdi0, sdi1, csN0, csN1, sclk0, sclk1, val0, val1;
  logic [9:0]  res0, res1;
  logic [15:0] ext0, ext1;
  int c0, f0, c1, f1;
  int topChecks = 0, topFails = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_adc_reader #(.CPOL(0)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .longFrame(longFrame), .bipolar(bipolar), .sdi(sdi0), .csN(csN0), .sclk(sclk0),
    .result(res0), .resultValid(val0), .resultExt(ext0));

  serial_adc_reader #(.CPOL(1)) dutHigh (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .longFrame(longFrame), .bipolar(bipolar), .sdi(sdi1), .csN(csN1), .sclk(sclk1),
    .result(res1), .resultValid(val1), .resultExt(ext1));

  rd_monitor #(.CPOL(0), .HALF(HALF)) mon0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .longFrame(longFrame), .bipolar(bipolar), .csN(csN0), .sclk(sclk0),
    .result(res0), .resultValid(val0), .resultExt(ext0), .sdi(sdi0),
    .nChecks(c0), .nFails(f0));

  rd_monitor #(.CPOL(1), .HALF(HALF)) mon1 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .longFrame(longFrame), .bipolar(bipolar), .csN(csN1), .sclk(sclk1),
    .result(res1), .resultValid(val1), .resultExt(ext1), .sdi(sdi1),
    .nChecks(c1), .nFails(f1));

  task automatic topChk(bit ok, string tag, int act, int exp);
    topChecks++;
    if (!ok) begin
      topFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", topChecks + c0 + c1, topFails + f0 + f1);
    $finish;
  endtask

  initial begin
    waitCyc(4);
    // R1 reset state
    topChk(csN0 == 1'b1 && csN1 == 1'b1, "R1 csN high in reset", {csN0, csN1}, 3);
    topChk(sclk0 == 1'b0 && sclk1 == 1'b1, "R1 sclk idle in reset", {sclk0, sclk1}, 1);
    topChk(!val0 && !val1, "R1 valid low in reset", {val0, val1}, 0);
    @(negedge clk) rstN = 1'b1;
    waitCyc(3);
    topChk(csN0 && csN1 && !sclk0 && sclk1, "R1 idle after reset", {csN0, csN1, sclk0, sclk1}, 'hD);
    // single frames, both lengths, both extension modes; R8 extra starts mid-frame
    for (int i = 0; i < 8; i++) begin
      bipolar   = i[0];
      longFrame = (i >= 5);
      pulseStart();
      waitCyc(25);
      pulseStart();          // R8: ignored, frame still running
      waitCyc(100);
      pulseStart();          // R8: still ignored
      waitCyc(60);
    end
    // R9 continuous chaining, length switch on the fly, then stop
    bipolar = 1'b1; longFrame = 1'b0; contMode = 1'b1;
    pulseStart();
    waitCyc(700);
    longFrame = 1'b1;
    waitCyc(500);
    @(negedge clk) contMode = 1'b0;
    waitCyc(400);
    topChk(csN0 && csN1, "R9 stops when continuous mode drops", {csN0, csN1}, 3);
    topChk(mon0.frameNo >= 16 && mon1.frameNo >= 14, "R9 frames chained",
           mon0.frameNo, 16);
    topChk(mon0.expq.size() == 0 && mon1.expq.size() == 0, "R6 every frame published",
           mon0.expq.size() + mon1.expq.size(), 0);
    finished = 1;
    report();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      topChecks++; topFails++;
      $display("FAIL watchdog expired");
      finished = 1;
      report();
    end
  end
endmodule